// File: doc/BRIEF.md
# Vendor-Command Scratch Memory Front End

This block sits behind a bulk byte transport and turns fixed five-byte vendor commands into accesses on a 16-bit byte address space. Two opcodes do real work. One writes a single byte. The other streams a run of bytes back to the host. Any other opcode is swallowed without effect. Each access is steered by its address. An address inside one of the configured windows goes out on a window-memory port as a window index and an offset from the window's base. Every other address lands in a small internal byte store.

Two addresses in the internal store have side effects when they are written. The status address clears the bits written as one and keeps the rest. The trigger address stores the byte and, only for one magic value, emits a one-cycle start pulse toward a downstream engine. Window routing is decided before any special-register handling. A special address that a window covers therefore behaves as a plain window byte.

Top module: `xmem_front`

## Requirements
- R1: A command is five consecutive accepted input bytes. Byte 0 is the opcode. Opcode 0xE5 writes byte 1 as data to the address formed by bytes 2, 3 and 4, most significant first, keeping only the low 16 bits, so byte 2 is discarded.
- R2: Opcode 0xE4 reads. Byte 1 gives a count N and bytes 2 to 4 give the address as in R1. The block presents N bytes from consecutive addresses, wrapping from 0xFFFF to 0x0000, and moves on one byte for each cycle with out_valid and out_ready both high. N = 0 produces no output.
- R3: An input byte is taken only in a cycle with in_valid and in_ready both high. in_ready is low while read data is being presented and in the cycle in which a complete command is being executed.
- R4: By default there are three windows: index 0 covers 0xF000–0xFFFF, index 1 covers 0xA000–0xAFFF and index 2 covers 0xB000–0xB1FF. An access inside a window appears on the window port with win_sel equal to the index and win_off equal to the address minus that window's base, and it leaves the internal store untouched.
- R5: A write inside a window raises win_req and win_we together for exactly one cycle, the cycle after the final command byte is taken, with win_wdata equal to the data byte.
- R6: While a byte from a window is being presented, win_req is high, win_we is low and out_data equals win_rdata in that same cycle. The window port carries no read request at any other time.
- R7: Addresses outside every window use an internal store of 2^MEM_AW bytes indexed by the low MEM_AW address bits, so addresses that differ only above those bits alias to the same byte.
- R8: A write to 0xB296 that falls outside every window clears each stored bit that is one in the written value and keeps the other bits. The result reads back at that address and at its aliases.
- R9: A write of 0x0F to 0xB254 stores the byte and raises start_pulse for exactly one cycle, the cycle after the final command byte. Any other value at 0xB254 is stored with no pulse. An aliased address such as 0x0254 never pulses.
- R10: If a window covers the status or trigger address, a write there is a window write: there is no bit clearing and no start pulse.
- R11: A command with any other opcode is consumed in full. It causes no window access, no output byte, no pulse and no change to stored bytes.
- R12: After reset, in_ready is high and out_valid, win_req and start_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command byte offered |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Command byte can be taken |
| out_valid | output | 1 | Read byte presented |
| out_data | output | 8 | Read byte |
| out_ready | input | 1 | Host takes the read byte |
| win_req | output | 1 | Window access in this cycle |
| win_we | output | 1 | Window access is a write |
| win_sel | output | SEL_W | Index of the addressed window |
| win_off | output | 16 | Offset from the window base |
| win_wdata | output | 8 | Window write byte |
| win_rdata | input | 8 | Window read byte, valid in the same cycle |
| start_pulse | output | 1 | One-cycle trigger toward the downstream engine |

## Verification
The bench runs two instances on the same command stream. The first uses the default windows and MEM_AW = 10. At that size the aliasing between 0x0296 and 0xB296 is a simple way to preset status bits, and window 2 ends just below both special addresses. The second widens window 2 to 0x400 bytes so that it covers 0xB254 and 0xB296, which makes the window-first priority visible on the same writes that pulse and clear on the first instance. Reads cross the end of window 2 into internal storage and wrap from window 0 at 0xFFFF into address 0x0000 while out_ready is withheld at random.

// File: rtl/xmem_pkg.sv
// Package: shared constants and the parsed-command record for the
// vendor-command memory front end. Assumes byte-wide data and 16-bit addresses.
package xmem_pkg;
    localparam int ADDR_W   = 16;
    localparam int CMD_LEN  = 5;
    localparam int IDX_W    = $clog2(CMD_LEN);
    localparam logic [7:0] OP_WRITE = 8'hE5;
    localparam logic [7:0] OP_READ  = 8'hE4;

    typedef struct packed {
        logic [7:0]        op;
        logic [7:0]        arg;
        logic [ADDR_W-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/xmem_cmd_parser.sv
// Module: collects five command bytes and presents the parsed command for
// one cycle. Assumes the consumer executes a command in that one cycle;
// while it does, and while `busy` is high, no input byte is taken.
// Byte 2 (top address byte) is dropped, which truncates the address.
module xmem_cmd_parser
    import xmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       busy,
    output logic       cmd_valid,
    output cmd_t       cmd
);
    logic [IDX_W-1:0] idx;
    logic             take;

    // Byte acceptance: stall during execution and while a read streams.
    assign in_ready = !cmd_valid && !busy;
    assign take     = in_valid && in_ready;

    // Byte position counter and the one-cycle command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (take) begin
                if (idx == IDX_W'(CMD_LEN - 1)) begin
                    idx       <= '0;
                    cmd_valid <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Field capture by byte position; the top address byte is not kept.
    always_ff @(posedge clk) begin
        if (take) begin
            case (idx)
                IDX_W'(0): cmd.op         <= in_data;
                IDX_W'(1): cmd.arg        <= in_data;
                IDX_W'(3): cmd.addr[15:8] <= in_data;
                IDX_W'(4): cmd.addr[7:0]  <= in_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xmem_window_map.sv
// Module: combinational window decoder. Compares an address with every
// configured window and returns hit, window index and offset from the base.
// Assumes windows do not wrap past 0xFFFF; on overlap the lowest index wins.
module xmem_window_map #(
    parameter int NUM_WIN = 3,
    parameter int SEL_W   = 2,
    parameter logic [NUM_WIN-1:0][15:0] WIN_BASE = {16'hB000, 16'hA000, 16'hF000},
    parameter logic [NUM_WIN-1:0][16:0] WIN_SIZE = {17'h00200, 17'h01000, 17'h01000}
) (
    input  logic [15:0]      addr,
    output logic             hit,
    output logic [SEL_W-1:0] sel,
    output logic [15:0]      off
);
    logic [NUM_WIN-1:0] in_win;

    // One range comparator per window, in 17 bits so the end bound fits.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        assign in_win[g] = ({1'b0, addr} >= {1'b0, WIN_BASE[g]}) &&
                           ({1'b0, addr} <  ({1'b0, WIN_BASE[g]} + WIN_SIZE[g]));
    end

    // Priority pick: scan from the top so the lowest hitting index is kept.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        off = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                hit = 1'b1;
                sel = SEL_W'(i);
                off = addr - WIN_BASE[i];
            end
        end
    end
endmodule

// File: rtl/xmem_byte_store.sv
// Module: internal byte store of 2^MEM_AW bytes with an asynchronous read
// and one write port that either stores or clears the bits written as one.
// Assumes the contents are not reset; software presets what it reads.
module xmem_byte_store #(
    parameter int MEM_AW = 10,
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic [MEM_AW-1:0] addr,
    input  logic              we,
    input  logic              clr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Write port: plain store, or clear the bits set in wdata.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= clr ? (mem[addr] & ~wdata) : wdata;
        end
    end

    // Read port: contents at the current address, same cycle.
    assign rdata = mem[addr];
endmodule

// File: rtl/xmem_rd_seq.sv
// Module: read streamer. Loaded with a start address and a byte count, it
// presents addresses one at a time and advances on each accepted byte.
// Assumes start is never raised while active; a zero count never activates.
module xmem_rd_seq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] start_addr,
    input  logic [7:0]  start_cnt,
    input  logic        step,
    output logic        active,
    output logic [15:0] addr
);
    logic [7:0] left;

    // Load, advance with 16-bit wrap, and stop after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            addr   <= '0;
            left   <= '0;
        end else if (start && start_cnt != 8'd0) begin
            active <= 1'b1;
            addr   <= start_addr;
            left   <= start_cnt;
        end else if (active && step) begin
            addr <= addr + 16'd1;
            left <= left - 8'd1;
            if (left == 8'd1) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xmem_front.sv
// Module: top of the vendor-command memory front end. Parses commands,
// routes each access to a window port or the internal store, applies the
// clear-on-one status byte and the magic-value trigger. Assumes the window
// memory answers reads combinationally and accepts writes when win_req is high.
module xmem_front #(
    parameter int MEM_AW  = 10,
    parameter int NUM_WIN = 3,
    parameter logic [NUM_WIN-1:0][15:0] WIN_BASE = {16'hB000, 16'hA000, 16'hF000},
    parameter logic [NUM_WIN-1:0][16:0] WIN_SIZE = {17'h00200, 17'h01000, 17'h01000},
    parameter logic [15:0] STAT_ADDR = 16'hB296,
    parameter logic [15:0] TRIG_ADDR = 16'hB254,
    parameter logic [7:0]  TRIG_VAL  = 8'h0F,
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             win_req,
    output logic             win_we,
    output logic [SEL_W-1:0] win_sel,
    output logic [15:0]      win_off,
    output logic [7:0]       win_wdata,
    input  logic [7:0]       win_rdata,
    output logic             start_pulse
);
    import xmem_pkg::*;

    cmd_t        cmd;
    logic        cmd_valid;
    logic        rd_active;
    logic [15:0] rd_addr;
    logic [15:0] acc_addr;
    logic        hit;
    logic        is_wr;
    logic        is_rd;
    logic        store_we;
    logic [7:0]  store_rd;

    xmem_cmd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .busy      (rd_active),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    // Opcode decode; other opcodes fall through with no action.
    assign is_wr = cmd_valid && (cmd.op == OP_WRITE);
    assign is_rd = cmd_valid && (cmd.op == OP_READ);

    xmem_rd_seq u_rdseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (is_rd),
        .start_addr (cmd.addr),
        .start_cnt  (cmd.arg),
        .step       (out_ready),
        .active     (rd_active),
        .addr       (rd_addr)
    );

    // One shared access address: the streaming pointer, else the command's.
    assign acc_addr = rd_active ? rd_addr : cmd.addr;

    xmem_window_map #(
        .NUM_WIN  (NUM_WIN),
        .SEL_W    (SEL_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_wmap (
        .addr (acc_addr),
        .hit  (hit),
        .sel  (win_sel),
        .off  (win_off)
    );

    // Internal store is written only by commands that miss every window.
    assign store_we = is_wr && !hit;

    xmem_byte_store #(
        .MEM_AW (MEM_AW)
    ) u_store (
        .clk   (clk),
        .addr  (acc_addr[MEM_AW-1:0]),
        .we    (store_we),
        .clr   (cmd.addr == STAT_ADDR),
        .wdata (cmd.arg),
        .rdata (store_rd)
    );

    // Window port: write during command execution, read while streaming.
    assign win_req   = (is_wr || rd_active) && hit;
    assign win_we    = is_wr && hit;
    assign win_wdata = cmd.arg;

    // Read stream output from whichever side holds the current address.
    assign out_valid = rd_active;
    assign out_data  = hit ? win_rdata : store_rd;

    // Trigger: full-address match on an internal write of the magic value.
    assign start_pulse = store_we && (cmd.addr == TRIG_ADDR) && (cmd.arg == TRIG_VAL);
endmodule

// File: rtl/xmem_front_chk.sv
// Module: protocol checker for xmem_front, attached to every instance by
// the bind below. Observes ports only; it assumes rst_n low for the first edge.
module xmem_front_chk #(
    parameter int NUM_WIN = 3,
    parameter int SEL_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             win_req,
    input logic             win_we,
    input logic [SEL_W-1:0] win_sel,
    input logic             start_pulse
);
    // No command byte is taken while read data is presented.
    assert_input_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // A byte that is not taken stays presented with the same routing.
    assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(win_req) && $stable(win_sel)));

    // Streaming window accesses are never writes.
    assert_read_not_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && out_valid) |-> !win_we);

    // A window access always names a configured window.
    assert_sel_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_req |-> (int'(win_sel) < NUM_WIN));

    // The start pulse is a single cycle wide.
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // A pulse never coincides with a window access.
    assert_pulse_not_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !win_req);

    // Outputs come out of reset idle.
    assert_reset_idle_R12: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid && !win_req && !start_pulse));
endmodule

bind xmem_front xmem_front_chk #(
    .NUM_WIN (NUM_WIN),
    .SEL_W   (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .win_req     (win_req),
    .win_we      (win_we),
    .win_sel     (win_sel),
    .start_pulse (start_pulse)
);

// File: tb/xmem_front_test.sv
`timescale 1ns/1ps
// Bench: scoreboard for xmem_front. uut has the default windows; uut_pri
// widens window 2 over both special addresses. Driver tasks queue the
// expected bytes and window writes; a negedge monitor pops and compares.
module xmem_front_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_ready;

    logic       u_in_ready, u_out_valid, u_win_req, u_win_we, u_pulse;
    logic [7:0] u_out_data, u_win_wdata, u_win_rdata;
    logic [1:0] u_win_sel;
    logic [15:0] u_win_off;
    logic       p_in_ready, p_out_valid, p_win_req, p_win_we, p_pulse;
    logic [7:0] p_out_data, p_win_wdata, p_win_rdata;
    logic [1:0] p_win_sel;
    logic [15:0] p_win_off;

    int n_chk = 0;
    int n_err = 0;
    int u_pulses = 0;
    int p_pulses = 0;
    int exp_u_pulses = 0;
    int stall_seen = 0;
    bit done = 1'b0;
    logic [7:0]  model [1024];
    logic [7:0]  exp_rd [$];
    logic [25:0] exp_uw [$];
    logic [25:0] exp_pw [$];
    logic [7:0]  lfsr;

    always #4 clk = ~clk;

    // Window memory contents seen by reads: a fixed pattern of index and offset.
    function automatic logic [7:0] wpat(input int sel, input logic [15:0] off);
        return off[7:0] + {off[11:8], 4'h0} + 8'(sel) * 8'h3B;
    endfunction

    // Window decode from R4 (wide=1 widens window 2 to 0x400 bytes).
    function automatic bit win_of(input logic [15:0] a, input bit wide,
                                  output int sel, output logic [15:0] off);
        sel = 0; off = 16'h0;
        if (a >= 16'hF000) begin sel = 0; off = a - 16'hF000; return 1'b1; end
        if (a >= 16'hA000 && a < 16'hB000) begin sel = 1; off = a - 16'hA000; return 1'b1; end
        if (a >= 16'hB000 && a < (wide ? 16'hB400 : 16'hB200)) begin
            sel = 2; off = a - 16'hB000; return 1'b1;
        end
        return 1'b0;
    endfunction

    assign u_win_rdata = wpat(int'(u_win_sel), u_win_off);
    assign p_win_rdata = wpat(int'(p_win_sel), p_win_off);

    xmem_front uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(u_in_ready), .out_valid(u_out_valid), .out_data(u_out_data),
        .out_ready(out_ready), .win_req(u_win_req), .win_we(u_win_we),
        .win_sel(u_win_sel), .win_off(u_win_off), .win_wdata(u_win_wdata),
        .win_rdata(u_win_rdata), .start_pulse(u_pulse)
    );

    xmem_front #(
        .WIN_SIZE({17'h00400, 17'h01000, 17'h01000})
    ) uut_pri (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(p_in_ready), .out_valid(p_out_valid), .out_data(p_out_data),
        .out_ready(out_ready), .win_req(p_win_req), .win_we(p_win_we),
        .win_sel(p_win_sel), .win_off(p_win_off), .win_wdata(p_win_wdata),
        .win_rdata(p_win_rdata), .start_pulse(p_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Random host back-pressure on the read stream.
    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr      <= 8'hA5;
            out_ready <= 1'b1;
        end else begin
            lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready <= lfsr[0] | lfsr[2];
        end
    end

    // Monitor: compare each handshake and window write against the queues.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (u_out_valid && out_ready) begin
                if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected byte", 32'(u_out_data), 32'hx);
                else begin
                    logic [7:0] e;
                    e = exp_rd.pop_front();
                    chk(u_out_data === e, "R2 read byte", 32'(u_out_data), 32'(e));
                end
            end
            if (u_out_valid) begin
                stall_seen++;
                if (u_in_ready) chk(1'b0, "R3 input open during read", 32'(u_in_ready), 32'h0);
            end
            if (u_win_req && !u_win_we && !u_out_valid)
                chk(1'b0, "R6 stray window read", 32'(u_win_off), 32'hx);
            if (u_win_req && u_win_we) begin
                if (exp_uw.size() == 0)
                    chk(1'b0, "R5 unexpected window write", {6'h0, u_win_sel, u_win_off, u_win_wdata}, 32'hx);
                else begin
                    logic [25:0] e;
                    e = exp_uw.pop_front();
                    chk({u_win_sel, u_win_off, u_win_wdata} === e, "R5 window write",
                        {6'h0, u_win_sel, u_win_off, u_win_wdata}, {6'h0, e});
                end
            end
            if (p_win_req && p_win_we) begin
                if (exp_pw.size() == 0)
                    chk(1'b0, "R10 unexpected window write", {6'h0, p_win_sel, p_win_off, p_win_wdata}, 32'hx);
                else begin
                    logic [25:0] e;
                    e = exp_pw.pop_front();
                    chk({p_win_sel, p_win_off, p_win_wdata} === e, "R10 window write",
                        {6'h0, p_win_sel, p_win_off, p_win_wdata}, {6'h0, e});
                end
            end
            if (u_pulse) u_pulses++;
            if (p_pulse) p_pulses++;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!u_in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [7:0] arg, input logic [23:0] a);
        send_byte(op);
        send_byte(arg);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
    endtask

    // Driver: single-byte write with expectations for both instances.
    task automatic wr(input logic [23:0] a24, input logic [7:0] d);
        logic [15:0] a, off;
        int sel;
        a = a24[15:0];
        if (win_of(a, 1'b0, sel, off)) exp_uw.push_back({2'(sel), off, d});
        else begin
            if (a == 16'hB296) model[a[9:0]] = model[a[9:0]] & ~d;
            else model[a[9:0]] = d;
            if (a == 16'hB254 && d == 8'h0F) exp_u_pulses++;
        end
        if (win_of(a, 1'b1, sel, off)) exp_pw.push_back({2'(sel), off, d});
        send_cmd(8'hE5, d, a24);
    endtask

    // Driver: read of n bytes, expected bytes queued before the command.
    task automatic rd(input logic [23:0] a24, input int n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] a, off;
            int sel;
            a = a24[15:0] + 16'(i);
            if (win_of(a, 1'b0, sel, off)) exp_rd.push_back(wpat(sel, off));
            else exp_rd.push_back(model[a[9:0]]);
        end
        send_cmd(8'hE4, 8'(n), a24);
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_rd.size() != 0 || u_out_valid || !u_in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(u_in_ready === 1'b1, "R12 in_ready", 32'(u_in_ready), 32'h1);
        chk(u_out_valid === 1'b0, "R12 out_valid", 32'(u_out_valid), 32'h0);
        chk(u_win_req === 1'b0 && u_pulse === 1'b0, "R12 win_req/start_pulse",
            {30'h0, u_win_req, u_pulse}, 32'h0);
        rst_n = 1'b1;

        // R1: plain write, truncated address, read back.
        wr(24'h000040, 8'h3C);
        wr(24'h5A0123, 8'hA7);
        rd(24'h000123, 1);
        rd(24'h000040, 1);
        drain();

        // R4/R5: writes into each window and just past window 2.
        wr(24'h00F010, 8'h91);
        wr(24'h00A7FF, 8'h12);
        wr(24'h00B1FF, 8'h34);
        wr(24'h00B200, 8'h11);
        wr(24'h00B201, 8'h22);
        wr(24'h000000, 8'hC1);
        wr(24'h000001, 8'hC2);
        drain();
        chk(exp_uw.size() == 0, "R5 all window writes seen", 32'(exp_uw.size()), 32'h0);

        // R4/R6/R7: read across the end of window 2 into internal storage.
        rd(24'h00B1FE, 4);
        // R2: wrap from window 0 at 0xFFFF into 0x0000.
        rd(24'h00FFFE, 4);
        rd(24'h00A000, 6);
        // R7: aliases of 0xB200/0xB201.
        rd(24'h000200, 2);
        drain();
        chk(stall_seen > 0, "R3 read stream observed", 32'(stall_seen), 32'h1);

        // R2: zero-length read yields nothing.
        rd(24'h000040, 0);
        repeat (6) @(negedge clk);
        chk(u_out_valid === 1'b0, "R2 zero count", 32'(u_out_valid), 32'h0);

        // R8: preset status through its alias, clear bits, read back.
        wr(24'h000296, 8'hF5);
        rd(24'h00B296, 1);
        wr(24'h00B296, 8'h05);
        rd(24'h000296, 1);
        wr(24'h00B296, 8'h00);
        rd(24'h00B296, 1);
        drain();

        // R9/R10: trigger behaviour; uut_pri sees window writes instead.
        wr(24'h00B254, 8'h0F);
        drain();
        chk(u_pulses == exp_u_pulses, "R9 pulse on magic value", 32'(u_pulses), 32'(exp_u_pulses));
        rd(24'h00B254, 1);
        wr(24'h00B254, 8'h0E);
        rd(24'h00B254, 1);
        wr(24'h000254, 8'h0F);
        rd(24'h00B254, 1);
        drain();
        chk(u_pulses == 1, "R9 no pulse for other value or alias", 32'(u_pulses), 32'h1);
        chk(p_pulses == 0, "R10 no pulse inside window", 32'(p_pulses), 32'h0);
        chk(exp_pw.size() == 0, "R10 window writes seen", 32'(exp_pw.size()), 32'h0);

        // R11: unknown opcodes aimed at a window and at stored data.
        send_cmd(8'h7A, 8'h99, 24'h00F010);
        send_cmd(8'h00, 8'hE4, 24'h000040);
        repeat (6) @(negedge clk);
        chk(u_out_valid === 1'b0 && u_win_req === 1'b0, "R11 unknown opcode idle",
            {30'h0, u_out_valid, u_win_req}, 32'h0);
        rd(24'h000040, 1);
        drain();
        chk(u_pulses == 1, "R11 no pulse", 32'(u_pulses), 32'h1);
        chk(exp_rd.size() == 0 && exp_uw.size() == 0, "R2 queues empty",
            32'(exp_rd.size() + exp_uw.size()), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule